// File: doc/BRIEF.md
# Cascadable Column Row Loader

This block gathers one display row of gray-scale codes into a wide column register and holds the finished row steady for a downstream converter. Each clock edge can take one input word. A word carries three 6-bit dots, so a 240-column row fills in 80 clocks. A loader takes words only while it holds the load token.

A start pulse arriving on the entry pin gives the loader the token. The entry pin is picked by the direction input. After the loader has taken its last word group, it emits a one-clock start pulse on the opposite pin. That pulse hands the token to the next loader in a chain.

A rising edge on the strobe input copies the collected row into the output latch and drops any token still held. Before any start pulse is accepted, the loader needs one strobe after reset.

Top module: `col_loader`

## Requirements
- R1: A synchronous reset clears the data register, the output latch `cols`, the token and both start outputs to zero.
- R2: After reset, start pulses are ignored until the first rising edge of `strobe`. Until then no word is captured and no start pulse is emitted.
- R3: Input dot 0 is `din[5:0]`, dot 1 is `din[11:6]` and dot 2 is `din[17:12]`. With `dir` high, the k-th word of a load (k from 0) fills columns 3k, 3k+1 and 3k+2, so it lands on `cols[18k +: 18]` with dot 0 in the lowest column.
- R4: With `dir` low, the k-th word fills the group at the far end, `cols[18(G-1-k) +: 18]` with G = NCOL/3, and the dot order inside the group is kept.
- R5: With `dir` high, only `start_r_i` is an entry pin; with `dir` low, only `start_l_i`. The word present on the edge that accepts the start pulse is the first word stored. A pulse on the other pin has no effect.
- R6: The edge that captures group G-1 raises a start output for exactly one clock. The output is `start_l_o` when `dir` is high and `start_r_o` when `dir` is low. The other start output stays low.
- R7: `cols` changes only on the clock edge at which `strobe` is seen rising, and it then takes the whole data register. Holding `strobe` high does not copy the register again.
- R8: A strobe rising edge clears the token. The word present on that edge and all words after it are not stored, and no start pulse is emitted for the unfinished load.
- R9: Words that arrive while no token is held leave the data register unchanged.
- R10: A start pulse accepted while a token is already held restarts the load at group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; words, start pulses and strobe are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Row transfer; its rising edge updates `cols` and clears the token |
| dir | input | 1 | Fill direction: high fills from column 0 upward, low from the top column downward |
| start_r_i | input | 1 | Start pulse entry used when `dir` is high |
| start_l_i | input | 1 | Start pulse entry used when `dir` is low |
| start_r_o | output | 1 | Outgoing start pulse when `dir` is low |
| start_l_o | output | 1 | Outgoing start pulse when `dir` is high |
| din | input | DOTS*DOTW (18) | Three dots of gray-scale code |
| cols | output | NCOL*DOTW (1440) | Latched row, column c at bits [6c +: 6] |

## Verification
The bench builds two loaders with NCOL set to 12, so each loader has four word groups. The first loader's start outputs drive the second loader's start inputs. A full row, the hand-off from one loader to the next and both fill orders therefore fit in a few dozen clocks. Each boundary can be checked on its exact edge: the pulse after the last group, a strobe cutting a load short, a restart in the middle of a load, and a strobe held high.

// File: rtl/col_loader.sv
module col_loader #(
  parameter int NCOL = 240,
  parameter int DOTW = 6,
  parameter int DOTS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   strobe,
  input  logic                   dir,
  input  logic                   start_r_i,
  input  logic                   start_l_i,
  output logic                   start_r_o,
  output logic                   start_l_o,
  input  logic [DOTS*DOTW-1:0]   din,
  output logic [NCOL*DOTW-1:0]   cols
);
  localparam int WW     = DOTS * DOTW;
  localparam int GROUPS = NCOL / DOTS;
  localparam int IW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic [NCOL*DOTW-1:0] shadow;
  logic [IW-1:0]        idx;
  logic                 active, armed, stb_q;

  wire          stb_rise = strobe & ~stb_q;
  wire          start_in = armed & (dir ? start_r_i : start_l_i);
  wire          take     = ~stb_rise & (start_in | active);
  wire [IW-1:0] grp      = start_in ? '0 : idx;
  wire [IW-1:0] slot     = dir ? grp : IW'(GROUPS - 1) - grp;
  wire          last     = (grp == IW'(GROUPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow    <= '0;
      cols      <= '0;
      idx       <= '0;
      active    <= 1'b0;
      armed     <= 1'b0;
      stb_q     <= 1'b0;
      start_l_o <= 1'b0;
      start_r_o <= 1'b0;
    end else begin
      stb_q     <= strobe;
      start_l_o <= 1'b0;
      start_r_o <= 1'b0;
      if (stb_rise) begin
        cols   <= shadow;
        armed  <= 1'b1;
        active <= 1'b0;
      end else if (take) begin
        shadow[slot*WW +: WW] <= din;
        if (last) begin
          active    <= 1'b0;
          start_l_o <= dir;
          start_r_o <= ~dir;
        end else begin
          active <= 1'b1;
          idx    <= grp + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int CW = 1440
) (
  input logic          clk,
  input logic          rst,
  input logic          strobe,
  input logic          dir,
  input logic          start_r_o,
  input logic          start_l_o,
  input logic [CW-1:0] cols
);
  logic stb_d;
  always_ff @(posedge clk) stb_d <= rst ? 1'b0 : strobe;

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (start_l_o || start_r_o) |=> !(start_l_o || start_r_o));

  // R6
  one_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_l_o, start_r_o}));

  // R6
  left_dir_chk: assert property (@(posedge clk) disable iff (rst)
    start_l_o |-> $past(dir));

  // R6
  right_dir_chk: assert property (@(posedge clk) disable iff (rst)
    start_r_o |-> !$past(dir));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cols) |-> $past(strobe && !stb_d));

  // R8
  strobe_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !stb_d) |=> !(start_l_o || start_r_o));
endmodule

bind col_loader col_loader_chk #(.CW(NCOL*DOTW)) chk_i (
  .clk(clk), .rst(rst), .strobe(strobe), .dir(dir),
  .start_r_o(start_r_o), .start_l_o(start_l_o), .cols(cols)
);

// File: tb/col_loader_tb_top.sv
module col_loader_tb_top;
  localparam int NC = 12, DW = 6, DS = 3;
  localparam int G = NC / DS, WW = DS * DW, CW = NC * DW;
  localparam logic [WW-1:0] VEC [8] = '{
    18'h01083, 18'h3F000, 18'h0003F, 18'h2A955,
    18'h15AAA, 18'h3FFFF, 18'h10204, 18'h20408
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, strobe = 1'b0, dir = 1'b1, a_r_i = 1'b0, a_l_i = 1'b0;
  logic [WW-1:0] din = '0;
  logic a_r_o, a_l_o, b_r_o, b_l_o;
  logic [CW-1:0] cols_a, cols_b;

  col_loader #(.NCOL(NC), .DOTW(DW), .DOTS(DS)) dut_i (
    .clk(clk), .rst(rst), .strobe(strobe), .dir(dir),
    .start_r_i(a_r_i), .start_l_i(a_l_i),
    .start_r_o(a_r_o), .start_l_o(a_l_o), .din(din), .cols(cols_a));

  col_loader #(.NCOL(NC), .DOTW(DW), .DOTS(DS)) dut_b_i (
    .clk(clk), .rst(rst), .strobe(strobe), .dir(dir),
    .start_r_i(a_l_o), .start_l_i(a_r_o),
    .start_r_o(b_r_o), .start_l_o(b_l_o), .din(din), .cols(cols_b));

  int errs = 0, checks = 0, wrong_pin = 0;
  logic [CW-1:0] shA = '0, shB = '0, latA = '0, latB = '0;

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] put(input logic [CW-1:0] sh, input logic d,
                                        input int g, input logic [WW-1:0] w);
    int p = d ? g : G - 1 - g;
    sh[p*WW +: WW] = w;
    return sh;
  endfunction

  always @(negedge clk)
    if (!rst && ((dir && (a_r_o || b_r_o)) || (!dir && (a_l_o || b_l_o))))
      wrong_pin++;

  task automatic fire();
    @(negedge clk); strobe = 1'b1; a_r_i = 1'b0; a_l_i = 1'b0;
    @(negedge clk); strobe = 1'b0;
    latA = shA; latB = shB;
  endtask

  task automatic load_pair(input logic d, input string req);
    for (int i = 0; i < 2*G; i++) begin
      @(negedge clk);
      if (i == G)     check({req, " R6 A pulse out"}, CW'(d ? a_l_o : a_r_o), CW'(1));
      if (i == G + 1) check({req, " R6 A pulse width"}, CW'(a_l_o | a_r_o), '0);
      if (i == G + 1) check({req, " R7 latch stable during load"}, cols_a, latA);
      a_r_i = (i == 0) && d;
      a_l_i = (i == 0) && !d;
      din   = VEC[i];
      if (i < G) shA = put(shA, d, i, VEC[i]);
      else       shB = put(shB, d, i - G, VEC[i]);
    end
    @(negedge clk);
    check({req, " R6 B pulse out"}, CW'(d ? b_l_o : b_r_o), CW'(1));
    a_r_i = 1'b0; a_l_i = 1'b0; din = '0;
    @(negedge clk);
    check({req, " R6 B pulse width"}, CW'(b_l_o | b_r_o), '0);
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset cols A", cols_a, '0);
    check("R1 reset cols B", cols_b, '0);
    check("R1 reset pulses", CW'({a_r_o, a_l_o, b_r_o, b_l_o}), '0);

    // R2: not armed yet
    for (int i = 0; i < G + 1; i++) begin
      @(negedge clk);
      a_r_i = (i == 0); din = VEC[i];
    end
    @(negedge clk);
    check("R2 no pulse before first strobe", CW'(a_l_o), '0);
    din = '0; a_r_i = 1'b0;
    fire();
    check("R2 nothing captured A", cols_a, '0);
    check("R2 nothing captured B", cols_b, '0);

    // R3: vector table walk, ascending fill
    dir = 1'b1;
    load_pair(1'b1, "R3");
    fire();
    check("R3 ascending A", cols_a, latA);
    check("R3 ascending B", cols_b, latB);

    // R5: wrong entry pin, R9: tokenless data
    for (int i = 0; i < G; i++) begin
      @(negedge clk);
      a_l_i = (i == 0); din = ~VEC[i];
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      a_l_i = 1'b0; din = VEC[i] ^ 18'h2AAAA;
    end
    fire();
    check("R5 wrong pin ignored", cols_a, latA);
    check("R9 tokenless data ignored", cols_b, latB);

    // R4: descending fill
    dir = 1'b0;
    load_pair(1'b0, "R4");
    fire();
    check("R4 descending A", cols_a, latA);
    check("R4 descending B", cols_b, latB);

    // R7: strobe held high copies only once
    dir = 1'b1;
    @(negedge clk); strobe = 1'b1;
    load_pair(1'b1, "R7");
    check("R7 held strobe no recopy A", cols_a, latA);
    check("R7 held strobe no recopy B", cols_b, latB);
    @(negedge clk); strobe = 1'b0;
    fire();
    check("R7 new row after release", cols_a, latA);

    // R8: strobe cuts a load short
    @(negedge clk); a_r_i = 1'b1; din = 18'h11111; shA = put(shA, 1'b1, 0, 18'h11111);
    @(negedge clk); a_r_i = 1'b0; din = 18'h22222; shA = put(shA, 1'b1, 1, 18'h22222);
    @(negedge clk); strobe = 1'b1; din = 18'h33333;
    @(negedge clk); strobe = 1'b0; din = 18'h04444;
    latA = shA; latB = shB;
    check("R8 latch at cut", cols_a, latA);
    @(negedge clk); din = 18'h05555;
    @(negedge clk); din = '0;
    check("R8 no pulse after cut", CW'(a_l_o | a_r_o), '0);
    fire();
    check("R8 later words dropped A", cols_a, latA);
    check("R8 chain untouched B", cols_b, latB);

    // R10: restart mid-load
    for (int i = 0; i < G + 2; i++) begin
      @(negedge clk);
      a_r_i = (i == 0) || (i == 2);
      din = VEC[i] ^ 18'h0F0F0;
      shA = put(shA, 1'b1, (i < 2) ? i : i - 2, VEC[i] ^ 18'h0F0F0);
    end
    for (int i = 0; i < G; i++) begin
      @(negedge clk);
      if (i == 0) check("R10 pulse after restarted row", CW'(a_l_o), CW'(1));
      a_r_i = 1'b0;
      din = VEC[i + 4] ^ 18'h3C3C3;
      shB = put(shB, 1'b1, i, VEC[i + 4] ^ 18'h3C3C3);
    end
    @(negedge clk); din = '0;
    fire();
    check("R10 restart A", cols_a, latA);
    check("R10 handoff B", cols_b, latB);

    check("R6 unused pin stayed low", CW'(wrong_pin), '0);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset A", cols_a, '0);
    check("R1 mid-run reset B", cols_b, '0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule